// File: doc/BRIEF.md
# Character-Cell Raster Address Generator

This block follows the beam of a video raster by counting pixel clocks and video lines. It maps the beam position onto a grid of character cells for an on-screen text overlay. A horizontal sync pulse restarts the pixel count, and each line advances the line count. A vertical sync pulse restarts the field. If vertical sync goes missing, a field-length flywheel restarts the field on its own. The character window is 24 columns by 12 rows of cells, and each cell is 12 pixels wide and 18 lines tall. The window can be moved in coarse steps from the sync edges. It can be enlarged by 1x to 4x on each axis independently, and the part that falls past the active area is clipped.

While the beam is inside the window, the block reports which cell it is in and which pixel and scan line inside that cell. It also gives a linear cell index for fetching a character code from display memory. A separate flag marks the region a downstream mixer should blank. The extent of that region is chosen by a 2-bit mode. Font storage, video conversion and sync separation belong to neighbouring blocks.

Top module: `char_raster_addr`

## Requirements
- R1: While reset is asserted, and after it until the first horizontal and vertical sync, `disp_active` and `blank_win` are 0 and every index output is 0.
- R2: Horizontal position 0 is the clock cycle after the one in which `hsync` is sampled high, and the position rises by one each clock after that. The window starts at position `h_start*4`.
- R3: Line 0 is the line that starts with the `hsync` on which the field restarts, and each following `hsync` advances the line. The window starts at line `v_start*2`.
- R4: Inside the window, `cell_px` counts 0 to 11. It advances once every `h_size+1` clocks. `char_col` advances after each `12*(h_size+1)` clocks.
- R5: Inside the window, `cell_ln` counts 0 to 17. It advances once every `v_size+1` lines. `char_row` advances after each `18*(v_size+1)` lines.
- R6: `cell_index` equals `char_row*24 + char_col` and holds steady across every pixel of a cell.
- R7: Outside the window, `disp_active` is 0 and `char_row`, `char_col`, `cell_px`, `cell_ln` and `cell_index` are 0.
- R8: No position at or past the active-area limit is inside the window. The limit is position 1400 horizontally and line 290 vertically. Cells enlarged past that edge are therefore cut off.
- R9: With no `vsync`, the field restarts by itself. With `prog_scan`=1, every field is 313 lines. With `prog_scan`=0, fields alternate between 312 and 313 lines (312.5 on average). After reset, the first field of this alternation is 312 lines.
- R10: A `vsync` sampled together with `hsync` restarts the field at line 0 and flips the field parity used by R9.
- R11: `blank_mode` selects `blank_win`, evaluated in the same cycle as the other outputs. 0 gives 0. 1 gives `disp_active`. 2 gives the cell interior, meaning active with `cell_px` not 0 or 11 and `cell_ln` not 0 or 17. 3 gives the full active area, meaning horizontal position below 1400 and line below 290.
- R12: The window ends after the last column or row: `24*12*(h_size+1)` clocks wide and `12*18*(v_size+1)` lines tall, unless it is clipped first by R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync pulse, one clock wide, active high |
| vsync | input | 1 | Vertical sync pulse, sampled with `hsync` |
| h_start | input | OFS_W (6) | Horizontal window offset, in 4-clock steps |
| v_start | input | OFS_W (6) | Vertical window offset, in 2-line steps |
| h_size | input | 2 | Horizontal magnification minus one |
| v_size | input | 2 | Vertical magnification minus one |
| blank_mode | input | 2 | Blanking extent select (R11) |
| prog_scan | input | 1 | 1 = 313-line fields, 0 = alternating 312/313 |
| disp_active | output | 1 | Beam inside the character window |
| char_row | output | ROW_W (4) | Character row index |
| char_col | output | COL_W (5) | Character column index |
| cell_px | output | PX_W (4) | Pixel column within the cell |
| cell_ln | output | LN_W (5) | Scan line within the cell |
| cell_index | output | IDX_W (9) | Linear cell index row*COLS+col |
| blank_win | output | 1 | Blanking region flag |

## Verification
The bench builds the block with a 5-by-3 array of 3-by-4 cells. It uses an active area of 60 clocks by 30 lines, a 40-line field and 80-clock lines. With these values, a full field takes a few thousand clocks. Clipping at the area edge is reached at every magnification. Offsets of zero, offsets just below the edge, and several field-flywheel cycles in both scan modes all fit in one short run. The behavioural model works out every output from the beam coordinates by division and modulo, and is compared with the design on every clock.

// File: rtl/crr_pkg.sv
package crr_pkg;

  typedef enum logic [1:0] {
    BLK_NONE  = 2'd0,
    BLK_CELL  = 2'd1,
    BLK_INNER = 2'd2,
    BLK_AREA  = 2'd3
  } blank_sel_e;

endpackage

// File: rtl/crr_axis.sv
// One raster axis: position since restart, window entry, repeat/sub/index counters.
module crr_axis #(
  parameter int CELLS   = 24,
  parameter int CELL_SZ = 12,
  parameter int UNIT    = 4,
  parameter int OFS_W   = 6,
  parameter int POS_W   = 11,
  parameter int AREA    = 1400,
  parameter int IDX_W   = 5,
  parameter int SUB_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [1:0]       mag_sel,
  output logic             in_win,
  output logic             in_area,
  output logic [IDX_W-1:0] idx,
  output logic [SUB_W-1:0] sub
);

  localparam logic [POS_W-1:0] AREA_P   = POS_W'(AREA);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CELL_SZ - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELLS - 1);

  logic [POS_W-1:0] pos_q, pos_d, pos_inc, start_pos;
  logic             in_q, in_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [1:0]       rep_q, rep_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;
  logic             last_rep, last_sub, last_idx;

  assign start_pos = POS_W'(start_ofs) * POS_W'(UNIT);
  assign pos_inc   = (pos_q == '1) ? pos_q : pos_q + 1'b1;
  assign last_rep  = (rep_q == mag_sel);
  assign last_sub  = (sub_q == SUB_LAST);
  assign last_idx  = (idx_q == IDX_LAST);
  assign upd_en    = restart | advance;

  always_comb begin
    pos_d = pos_q;
    in_d  = in_q;
    sub_d = sub_q;
    rep_d = rep_q;
    idx_d = idx_q;
    if (restart) begin
      pos_d = '0;
      in_d  = (start_pos == '0);
      sub_d = '0;
      rep_d = '0;
      idx_d = '0;
    end else if (advance) begin
      pos_d = pos_inc;
      if (in_q) begin
        if ((pos_inc >= AREA_P) || (last_rep && last_sub && last_idx)) begin
          in_d  = 1'b0;
          sub_d = '0;
          rep_d = '0;
          idx_d = '0;
        end else if (last_rep) begin
          rep_d = '0;
          if (last_sub) begin
            sub_d = '0;
            idx_d = idx_q + 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end else if ((pos_inc == start_pos) && (pos_inc < AREA_P)) begin
        in_d  = 1'b1;
        sub_d = '0;
        rep_d = '0;
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '1;
      in_q  <= 1'b0;
      sub_q <= '0;
      rep_q <= '0;
      idx_q <= '0;
    end else if (upd_en) begin
      pos_q <= pos_d;
      in_q  <= in_d;
      sub_q <= sub_d;
      rep_q <= rep_d;
      idx_q <= idx_d;
    end
  end

  assign in_win  = in_q;
  assign in_area = (pos_q < AREA_P);
  assign idx     = idx_q;
  assign sub     = sub_q;

endmodule

// File: rtl/crr_field.sv
// Field line counter with flywheel restart and interlace parity.
module crr_field #(
  parameter int FIELD_LINES = 313,
  parameter int LCNT_W      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic prog_scan,
  output logic v_restart,
  output logic v_advance
);

  localparam logic [LCNT_W-1:0] LONG_LAST  = LCNT_W'(FIELD_LINES - 1);
  localparam logic [LCNT_W-1:0] SHORT_LAST = LCNT_W'(FIELD_LINES - 2);

  logic [LCNT_W-1:0] lcnt_q, lcnt_d, last_line;
  logic              odd_q, odd_d;
  logic              wrap, upd_en;

  assign last_line = (prog_scan || odd_q) ? LONG_LAST : SHORT_LAST;
  assign wrap      = hsync && !vsync && (lcnt_q >= last_line);
  assign upd_en    = hsync | vsync;

  always_comb begin
    lcnt_d = lcnt_q;
    odd_d  = odd_q;
    if (vsync || wrap) begin
      lcnt_d = '0;
      odd_d  = ~odd_q;
    end else if (hsync) begin
      lcnt_d = lcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt_q <= '0;
      odd_q  <= 1'b0;
    end else if (upd_en) begin
      lcnt_q <= lcnt_d;
      odd_q  <= odd_d;
    end
  end

  assign v_restart = vsync | wrap;
  assign v_advance = hsync;

endmodule

// File: rtl/crr_blank.sv
// Blanking region select.
module crr_blank
  import crr_pkg::*;
#(
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  parameter int PX_W   = 4,
  parameter int LN_W   = 5
) (
  input  blank_sel_e       mode,
  input  logic             active,
  input  logic [PX_W-1:0]  px,
  input  logic [LN_W-1:0]  ln,
  input  logic             h_area,
  input  logic             v_area,
  output logic             blank
);

  localparam logic [PX_W-1:0] PX_LAST = PX_W'(CELL_W - 1);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(CELL_H - 1);

  logic inner;

  assign inner = active && (px != '0) && (px != PX_LAST) &&
                 (ln != '0) && (ln != LN_LAST);

  always_comb begin
    unique case (mode)
      BLK_NONE:  blank = 1'b0;
      BLK_CELL:  blank = active;
      BLK_INNER: blank = inner;
      BLK_AREA:  blank = h_area && v_area;
      default:   blank = 1'b0;
    endcase
  end

endmodule

// File: rtl/char_raster_addr.sv
module char_raster_addr
  import crr_pkg::*;
#(
  parameter int COLS        = 24,
  parameter int ROWS        = 12,
  parameter int CELL_W      = 12,
  parameter int CELL_H      = 18,
  parameter int OFS_W       = 6,
  parameter int H_UNIT      = 4,
  parameter int V_UNIT      = 2,
  parameter int H_AREA      = 1400,
  parameter int V_AREA      = 290,
  parameter int H_POS_W     = 11,
  parameter int V_POS_W     = 9,
  parameter int FIELD_LINES = 313,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int PX_W   = $clog2(CELL_W),
  localparam int LN_W   = $clog2(CELL_H),
  localparam int IDX_W  = $clog2(COLS * ROWS),
  localparam int LCNT_W = $clog2(FIELD_LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [OFS_W-1:0] h_start,
  input  logic [OFS_W-1:0] v_start,
  input  logic [1:0]       h_size,
  input  logic [1:0]       v_size,
  input  logic [1:0]       blank_mode,
  input  logic             prog_scan,
  output logic             disp_active,
  output logic [ROW_W-1:0] char_row,
  output logic [COL_W-1:0] char_col,
  output logic [PX_W-1:0]  cell_px,
  output logic [LN_W-1:0]  cell_ln,
  output logic [IDX_W-1:0] cell_index,
  output logic             blank_win
);

  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic v_restart, v_advance;

  crr_field #(
    .FIELD_LINES(FIELD_LINES),
    .LCNT_W     (LCNT_W)
  ) u_field (
    .clk      (clk),
    .rst_n    (rst_sn),
    .hsync    (hsync),
    .vsync    (vsync),
    .prog_scan(prog_scan),
    .v_restart(v_restart),
    .v_advance(v_advance)
  );

  logic             h_in, h_area_in, v_in, v_area_in;
  logic [COL_W-1:0] h_idx;
  logic [PX_W-1:0]  h_sub;
  logic [ROW_W-1:0] v_idx;
  logic [LN_W-1:0]  v_sub;

  crr_axis #(
    .CELLS(COLS), .CELL_SZ(CELL_W), .UNIT(H_UNIT), .OFS_W(OFS_W),
    .POS_W(H_POS_W), .AREA(H_AREA), .IDX_W(COL_W), .SUB_W(PX_W)
  ) u_haxis (
    .clk      (clk),
    .rst_n    (rst_sn),
    .restart  (hsync),
    .advance  (1'b1),
    .start_ofs(h_start),
    .mag_sel  (h_size),
    .in_win   (h_in),
    .in_area  (h_area_in),
    .idx      (h_idx),
    .sub      (h_sub)
  );

  crr_axis #(
    .CELLS(ROWS), .CELL_SZ(CELL_H), .UNIT(V_UNIT), .OFS_W(OFS_W),
    .POS_W(V_POS_W), .AREA(V_AREA), .IDX_W(ROW_W), .SUB_W(LN_W)
  ) u_vaxis (
    .clk      (clk),
    .rst_n    (rst_sn),
    .restart  (v_restart),
    .advance  (v_advance),
    .start_ofs(v_start),
    .mag_sel  (v_size),
    .in_win   (v_in),
    .in_area  (v_area_in),
    .idx      (v_idx),
    .sub      (v_sub)
  );

  logic act;
  assign act = h_in && v_in;

  assign disp_active = act;
  assign char_row    = act ? v_idx : '0;
  assign char_col    = act ? h_idx : '0;
  assign cell_px     = act ? h_sub : '0;
  assign cell_ln     = act ? v_sub : '0;
  assign cell_index  = act ? (IDX_W'(v_idx) * IDX_W'(COLS) + IDX_W'(h_idx)) : '0;

  crr_blank #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .PX_W(PX_W), .LN_W(LN_W)
  ) u_blank (
    .mode  (blank_sel_e'(blank_mode)),
    .active(act),
    .px    (cell_px),
    .ln    (cell_ln),
    .h_area(h_area_in),
    .v_area(v_area_in),
    .blank (blank_win)
  );

endmodule

// File: rtl/crr_checker.sv
module crr_checker #(
  parameter int PX_W  = 4,
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync,
  input logic [1:0]       h_size,
  input logic [1:0]       blank_mode,
  input logic             disp_active,
  input logic [PX_W-1:0]  cell_px,
  input logic [IDX_W-1:0] cell_index,
  input logic             blank_win
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!disp_active && !blank_win));

  assert_px_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active && $past(disp_active) && $stable(h_size)) |->
      ((cell_px == $past(cell_px)) || (cell_px == '0) ||
       ({1'b0, cell_px} == {1'b0, $past(cell_px)} + 1'b1)));

  assert_cell_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active && $past(disp_active) && !$past(vsync) && (cell_px != '0)) |->
      $stable(cell_index));

  assert_blank_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_mode == 2'd0) |-> !blank_win);

  assert_blank_cell_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_mode == 2'd1) |-> (blank_win == disp_active));

endmodule

bind char_raster_addr crr_checker #(
  .PX_W (PX_W),
  .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vsync      (vsync),
  .h_size     (h_size),
  .blank_mode (blank_mode),
  .disp_active(disp_active),
  .cell_px    (cell_px),
  .cell_index (cell_index),
  .blank_win  (blank_win)
);

// File: tb/sim_char_raster_addr.sv
`timescale 1ns/1ps
module sim_char_raster_addr;

  localparam int COLS = 5, ROWS = 3, CW = 3, CH = 4;
  localparam int HA = 60, VA = 30, FL = 40, LINE = 80;
  localparam int BIG = 100000;
  localparam int COL_W = $clog2(COLS), ROW_W = $clog2(ROWS);
  localparam int PX_W = $clog2(CW), LN_W = $clog2(CH), IDX_W = $clog2(COLS*ROWS);

  logic clk = 1'b0;
  logic rst_n, hsync, vsync, prog_scan;
  logic [5:0] h_start, v_start;
  logic [1:0] h_size, v_size, blank_mode;
  logic disp_active, blank_win;
  logic [ROW_W-1:0] char_row;
  logic [COL_W-1:0] char_col;
  logic [PX_W-1:0]  cell_px;
  logic [LN_W-1:0]  cell_ln;
  logic [IDX_W-1:0] cell_index;

  always #5 clk = ~clk;

  char_raster_addr #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CW), .CELL_H(CH),
    .H_AREA(HA), .V_AREA(VA), .H_POS_W(8), .V_POS_W(6), .FIELD_LINES(FL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .h_start(h_start), .v_start(v_start), .h_size(h_size), .v_size(v_size),
    .blank_mode(blank_mode), .prog_scan(prog_scan),
    .disp_active(disp_active), .char_row(char_row), .char_col(char_col),
    .cell_px(cell_px), .cell_ln(cell_ln), .cell_index(cell_index),
    .blank_win(blank_win)
  );

  int vectors = 0, fails = 0;
  string scen = "R1";
  bit finished = 1'b0;

  // beam model
  int hc, vl, lc, odd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc = BIG; vl = BIG; lc = 0; odd = 0;
    end else begin
      int flen;
      flen = (prog_scan || odd != 0) ? FL : FL - 1;
      if (hsync) hc = 0;
      else if (hc < BIG) hc = hc + 1;
      if (vsync || (hsync && lc >= flen - 1)) begin
        lc = 0; odd = 1 - odd; vl = 0;
      end else if (hsync) begin
        lc = lc + 1;
        if (vl < BIG) vl = vl + 1;
      end
    end
  end

  task automatic miss(input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s at %0t: actual %0d expected %0d", scen, what, $time, act, exp);
  endtask

  always @(negedge clk) begin
    int mh, mv, hs, vs, e_act, e_col, e_px, e_row, e_ln, e_idx, e_blk;
    bit xin, yin;
    mh = int'(h_size) + 1; mv = int'(v_size) + 1;
    hs = int'(h_start) * 4; vs = int'(v_start) * 2;
    xin = (hc >= hs) && (hc < hs + COLS*CW*mh) && (hc < HA);
    yin = (vl >= vs) && (vl < vs + ROWS*CH*mv) && (vl < VA);
    e_act = (xin && yin) ? 1 : 0;
    e_col = e_act ? (hc - hs) / (CW*mh) : 0;
    e_px  = e_act ? ((hc - hs) / mh) % CW : 0;
    e_row = e_act ? (vl - vs) / (CH*mv) : 0;
    e_ln  = e_act ? ((vl - vs) / mv) % CH : 0;
    e_idx = e_row * COLS + e_col;
    case (blank_mode)
      2'd0: e_blk = 0;
      2'd1: e_blk = e_act;
      2'd2: e_blk = (e_act && e_px != 0 && e_px != CW-1 && e_ln != 0 && e_ln != CH-1) ? 1 : 0;
      default: e_blk = (hc < HA && vl < VA) ? 1 : 0;
    endcase
    vectors++;
    if (int'(disp_active) != e_act) miss("R2 R3 R7 disp_active", int'(disp_active), e_act);
    if (int'(char_col) != e_col)    miss("R4 char_col", int'(char_col), e_col);
    if (int'(cell_px) != e_px)      miss("R4 cell_px", int'(cell_px), e_px);
    if (int'(char_row) != e_row)    miss("R5 char_row", int'(char_row), e_row);
    if (int'(cell_ln) != e_ln)      miss("R5 cell_ln", int'(cell_ln), e_ln);
    if (int'(cell_index) != e_idx)  miss("R6 cell_index", int'(cell_index), e_idx);
    if (int'(blank_win) != e_blk)   miss("R11 blank_win", int'(blank_win), e_blk);
  end

  task automatic one_line(input bit vs);
    @(posedge clk); #2 hsync = 1'b1; vsync = vs;
    @(posedge clk); #2 hsync = 1'b0; vsync = 1'b0;
    repeat (LINE - 2) @(posedge clk);
  endtask

  task automatic field(input string tag, input int hs, input int vs, input int hm,
                       input int vm, input int bm, input bit pg, input int nlines);
    @(posedge clk); #2;
    scen = tag;
    h_start = 6'(hs); v_start = 6'(vs); h_size = 2'(hm); v_size = 2'(vm);
    blank_mode = 2'(bm); prog_scan = pg;
    hsync = 1'b1; vsync = 1'b1;
    @(posedge clk); #2 hsync = 1'b0; vsync = 1'b0;
    repeat (LINE - 2) @(posedge clk);
    for (int i = 1; i < nlines; i++) one_line(1'b0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired in %s", scen);
    summary();
  end

  initial begin
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; prog_scan = 1'b0;
    h_start = '0; v_start = '0; h_size = '0; v_size = '0; blank_mode = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    scen = "R1";
    repeat (12) @(posedge clk);
    field("R3 R12 base", 2, 1, 0, 0, 0, 1'b1, FL);
    field("R12 mag2 cell-blank", 2, 1, 1, 1, 1, 1'b1, FL);
    field("R8 mag4 clip area-blank", 2, 1, 3, 3, 3, 1'b1, FL);
    field("R3 zero offset inner-blank", 0, 0, 2, 0, 2, 1'b1, FL);
    field("R8 offset near edge", 13, 14, 1, 0, 1, 1'b1, FL);
    field("R8 offset past edge", 15, 15, 0, 0, 3, 1'b1, 10);
    field("R10 vsync mid-field", 1, 2, 0, 1, 2, 1'b1, 17);
    field("R9 interlaced flywheel", 3, 1, 1, 0, 2, 1'b0, 3 * FL + 5);
    field("R9 progressive flywheel", 0, 3, 0, 2, 3, 1'b1, 2 * FL + 7);
    field("R10 R7 restart", 4, 0, 0, 0, 1, 1'b0, FL);
    summary();
  end

endmodule